// File: doc/BRIEF.md
# Bit-Band Alias Address Bridge

This bridge sits between an upstream bus master and a word-addressed peripheral register region. Besides passing ordinary word accesses to that region through unchanged, it opens a second, larger address window. In that window every 32-bit word stands for exactly one bit of the register region. Writing an alias word sets or clears that single bit: the bridge reads the register word, changes the one bit and writes the word back. Reading an alias word returns the chosen bit in bit 0. Software can therefore flip one pin-like bit with a single store and never has to mask or merge the neighbouring bits itself.

Both upstream channels and the downstream request channel use valid/ready handshakes. A master raises valid and keeps the request, or the response, stable until the matching ready is seen high at a clock edge. The bridge handles one access at a time. Upstream request ready is high only while the bridge is idle, so a new request cannot enter while a read-modify-write is still in progress. Downstream read data comes back on a valid-only response channel after any number of cycles. Downstream writes are finished once the request has been accepted.

Top module: `bitband_bridge`

## Requirements
- R1: A word read or write at an address inside the direct region `[DIRECT_BASE, DIRECT_BASE + 4*DIRECT_WORDS)` goes downstream unchanged. A read returns the downstream word and a write stores the upstream word.
- R2: The alias address for bit `b` (0 = LSB, 31 = MSB) of direct word `w` is `ALIAS_BASE + 128*w + 4*b`. Equivalently, each target byte owns 32 alias bytes and successive bits are 4 bytes apart. Address bits [1:0] inside the alias window are ignored.
- R3: On an alias write, only bit 0 of the write data sets the new bit value. Data bits 31..1 have no effect.
- R4: An alias write produces exactly one downstream read and then exactly one downstream write, both to the same word address. Only the selected bit changes and the other 31 bits keep their value.
- R5: An alias read returns the selected bit in bit 0 with bits 31..1 zero. It uses exactly one downstream read and no write.
- R6: Upstream request ready stays low from the acceptance of a request until its response has been accepted.
- R7: The bridge waits for the downstream read-valid pulse and works with any read latency and any downstream request stall.
- R8: An address outside both regions gets a response with the error flag set to 1 and read data 0, and causes no downstream request.
- R9: While the upstream response is valid and not yet accepted, it stays valid and its data and error flag stay stable.
- R10: While a downstream request is valid and not yet accepted, it stays valid and its address, direction and write data stay stable.
- R11: After reset, upstream request ready is 1, and upstream response valid and downstream request valid are 0.
- R12: Direct and alias accesses to the same stored bit see the same value, whichever path wrote it last.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| up_req_valid | input | 1 | Upstream request valid |
| up_req_ready | output | 1 | Upstream request ready (high only when idle) |
| up_req_write | input | 1 | 1 = write, 0 = read |
| up_req_addr | input | ADDR_W | Upstream byte address |
| up_req_wdata | input | 32 | Upstream write data |
| up_rsp_valid | output | 1 | Upstream response valid |
| up_rsp_ready | input | 1 | Upstream response ready |
| up_rsp_rdata | output | 32 | Response read data (0 for writes and errors) |
| up_rsp_err | output | 1 | 1 = address outside both regions |
| dn_req_valid | output | 1 | Downstream request valid |
| dn_req_ready | input | 1 | Downstream request ready |
| dn_req_write | output | 1 | 1 = write, 0 = read |
| dn_req_addr | output | ADDR_W | Word-aligned downstream address |
| dn_req_wdata | output | 32 | Downstream write data |
| dn_rsp_valid | input | 1 | Downstream read data valid (one-cycle pulse) |
| dn_rsp_rdata | input | 32 | Downstream read data |

## Verification
The bound checker watches the handshake rules on every cycle. These are the blocked request ready while an access is open, the stable response under back-pressure and the stable downstream request under stall. It also checks the shape of each access from the ports alone: no downstream traffic for an error, exactly two downstream transfers for an alias write, and zero upper bits for an alias read. Only the directed scenarios can show that values are correct. They confirm that the bit at a computed alias address is the one that changes, that neighbouring bits survive, that write data above bit 0 is ignored, that long read latencies are tolerated, and that a value written on one path reads back the same on the other.

// File: rtl/bb_pkg.sv
package bb_pkg;

  localparam int WORD_W    = 32;
  localparam int BIT_IDX_W = $clog2(WORD_W);
  localparam int ALIAS_STRIDE_SHIFT = 2;                      // 4 bytes per alias word
  localparam int ALIAS_WORD_SHIFT   = BIT_IDX_W + ALIAS_STRIDE_SHIFT; // 128 bytes per target word

  typedef enum logic [1:0] {
    ACC_DIRECT = 2'd0,
    ACC_ALIAS  = 2'd1,
    ACC_BAD    = 2'd2
  } acc_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_RD_REQ  = 3'd1,
    ST_RD_WAIT = 3'd2,
    ST_WR_REQ  = 3'd3,
    ST_RSP     = 3'd4
  } bb_state_e;

endpackage

// File: rtl/bb_decode.sv
module bb_decode
  import bb_pkg::*;
#(
  parameter int                ADDR_W       = 32,
  parameter logic [ADDR_W-1:0] DIRECT_BASE  = 'h4000_0000,
  parameter int                DIRECT_WORDS = 64,
  parameter logic [ADDR_W-1:0] ALIAS_BASE   = 'h4200_0000
) (
  input  logic [ADDR_W-1:0]    addr,
  output acc_kind_e            kind,
  output logic [ADDR_W-1:0]    word_addr,
  output logic [BIT_IDX_W-1:0] bit_idx
);

  localparam int DIRECT_BYTES = DIRECT_WORDS * (WORD_W / 8);
  localparam int ALIAS_BYTES  = DIRECT_BYTES * WORD_W;

  localparam logic [ADDR_W:0] D_LO = {1'b0, DIRECT_BASE};
  localparam logic [ADDR_W:0] D_HI = D_LO + (ADDR_W+1)'(DIRECT_BYTES);
  localparam logic [ADDR_W:0] A_LO = {1'b0, ALIAS_BASE};
  localparam logic [ADDR_W:0] A_HI = A_LO + (ADDR_W+1)'(ALIAS_BYTES);

  logic [ADDR_W:0]   addr_ext;
  logic              in_direct;
  logic              in_alias;
  logic [ADDR_W-1:0] alias_off;
  logic [ADDR_W-1:0] alias_word_off;
  logic [1:0]        unused_low_bits;

  assign addr_ext  = {1'b0, addr};
  assign in_direct = (addr_ext >= D_LO) && (addr_ext < D_HI);
  assign in_alias  = (addr_ext >= A_LO) && (addr_ext < A_HI);

  // offset into the alias window; bits [1:0] select a byte of the alias word and are ignored
  assign alias_off       = addr - ALIAS_BASE;
  assign unused_low_bits = alias_off[1:0];
  assign alias_word_off  = (alias_off >> ALIAS_WORD_SHIFT) << ALIAS_STRIDE_SHIFT;

  always_comb begin
    kind      = ACC_BAD;
    word_addr = '0;
    bit_idx   = '0;
    if (in_direct) begin
      kind      = ACC_DIRECT;
      word_addr = {addr[ADDR_W-1:2], 2'b00};
    end else if (in_alias) begin
      kind      = ACC_ALIAS;
      word_addr = DIRECT_BASE + alias_word_off;
      bit_idx   = alias_off[ALIAS_WORD_SHIFT-1:ALIAS_STRIDE_SHIFT];
    end
  end

endmodule

// File: rtl/bb_bitmerge.sv
module bb_bitmerge
  import bb_pkg::*;
(
  input  logic [WORD_W-1:0]    word_in,
  input  logic [BIT_IDX_W-1:0] sel,
  input  logic                 new_val,
  output logic [WORD_W-1:0]    word_out,
  output logic                 picked
);

  logic [WORD_W-1:0] sel_dec;
  logic [WORD_W-1:0] hit_bits;

  for (genvar i = 0; i < WORD_W; i++) begin : g_bit
    assign sel_dec[i]  = (sel == BIT_IDX_W'(i));
    assign word_out[i] = sel_dec[i] ? new_val : word_in[i];
    assign hit_bits[i] = sel_dec[i] & word_in[i];
  end

  assign picked = |hit_bits;

endmodule

// File: rtl/bb_ctrl.sv
module bb_ctrl
  import bb_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  // upstream request
  input  logic                 up_req_valid,
  output logic                 up_req_ready,
  input  logic                 up_req_write,
  input  logic [WORD_W-1:0]    up_req_wdata,
  // decode of the request address
  input  acc_kind_e            dec_kind,
  input  logic [ADDR_W-1:0]    dec_word_addr,
  input  logic [BIT_IDX_W-1:0] dec_bit_idx,
  // upstream response
  output logic                 up_rsp_valid,
  input  logic                 up_rsp_ready,
  output logic [WORD_W-1:0]    up_rsp_rdata,
  output logic                 up_rsp_err,
  // downstream request
  output logic                 dn_req_valid,
  input  logic                 dn_req_ready,
  output logic                 dn_req_write,
  output logic [ADDR_W-1:0]    dn_req_addr,
  output logic [WORD_W-1:0]    dn_req_wdata,
  // downstream read response
  input  logic                 dn_rsp_valid,
  input  logic [WORD_W-1:0]    dn_rsp_rdata,
  // bit merge
  output logic [BIT_IDX_W-1:0] cur_bit_idx,
  output logic                 cur_bit_val,
  input  logic [WORD_W-1:0]    merged_word,
  input  logic                 picked_bit
);

  bb_state_e         state_q;
  acc_kind_e         kind_q;
  logic              write_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] wdata_q;
  logic [WORD_W-1:0] rdata_q;
  logic              err_q;
  logic              up_fire;

  assign up_req_ready = (state_q == ST_IDLE);
  assign up_fire      = up_req_valid && up_req_ready;

  assign dn_req_valid = (state_q == ST_RD_REQ) || (state_q == ST_WR_REQ);
  assign dn_req_write = (state_q == ST_WR_REQ);
  assign dn_req_addr  = addr_q;
  assign dn_req_wdata = wdata_q;

  assign up_rsp_valid = (state_q == ST_RSP);
  assign up_rsp_rdata = rdata_q;
  assign up_rsp_err   = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      kind_q      <= ACC_DIRECT;
      write_q     <= 1'b0;
      addr_q      <= '0;
      wdata_q     <= '0;
      rdata_q     <= '0;
      err_q       <= 1'b0;
      cur_bit_idx <= '0;
      cur_bit_val <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (up_fire) begin
            kind_q      <= dec_kind;
            write_q     <= up_req_write;
            addr_q      <= dec_word_addr;
            wdata_q     <= up_req_wdata;
            rdata_q     <= '0;
            err_q       <= (dec_kind == ACC_BAD);
            cur_bit_idx <= dec_bit_idx;
            cur_bit_val <= up_req_wdata[0];
            if (dec_kind == ACC_BAD)
              state_q <= ST_RSP;
            else if (dec_kind == ACC_DIRECT && up_req_write)
              state_q <= ST_WR_REQ;
            else
              state_q <= ST_RD_REQ;
          end
        end
        ST_RD_REQ: begin
          if (dn_req_ready) state_q <= ST_RD_WAIT;
        end
        ST_RD_WAIT: begin
          if (dn_rsp_valid) begin
            if (kind_q == ACC_ALIAS) begin
              if (write_q) begin
                wdata_q <= merged_word;
                state_q <= ST_WR_REQ;
              end else begin
                rdata_q <= {{(WORD_W-1){1'b0}}, picked_bit};
                state_q <= ST_RSP;
              end
            end else begin
              rdata_q <= dn_rsp_rdata;
              state_q <= ST_RSP;
            end
          end
        end
        ST_WR_REQ: begin
          if (dn_req_ready) state_q <= ST_RSP;
        end
        ST_RSP: begin
          if (up_rsp_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge
  import bb_pkg::*;
#(
  parameter int                ADDR_W       = 32,
  parameter logic [ADDR_W-1:0] DIRECT_BASE  = 'h4000_0000,
  parameter int                DIRECT_WORDS = 64,
  parameter logic [ADDR_W-1:0] ALIAS_BASE   = 'h4200_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_req_valid,
  output logic              up_req_ready,
  input  logic              up_req_write,
  input  logic [ADDR_W-1:0] up_req_addr,
  input  logic [31:0]       up_req_wdata,
  output logic              up_rsp_valid,
  input  logic              up_rsp_ready,
  output logic [31:0]       up_rsp_rdata,
  output logic              up_rsp_err,
  output logic              dn_req_valid,
  input  logic              dn_req_ready,
  output logic              dn_req_write,
  output logic [ADDR_W-1:0] dn_req_addr,
  output logic [31:0]       dn_req_wdata,
  input  logic              dn_rsp_valid,
  input  logic [31:0]       dn_rsp_rdata
);

  acc_kind_e            dec_kind;
  logic [ADDR_W-1:0]    dec_word_addr;
  logic [BIT_IDX_W-1:0] dec_bit_idx;
  logic [BIT_IDX_W-1:0] cur_bit_idx;
  logic                 cur_bit_val;
  logic [WORD_W-1:0]    merged_word;
  logic                 picked_bit;

  bb_decode #(
    .ADDR_W      (ADDR_W),
    .DIRECT_BASE (DIRECT_BASE),
    .DIRECT_WORDS(DIRECT_WORDS),
    .ALIAS_BASE  (ALIAS_BASE)
  ) u_decode (
    .addr     (up_req_addr),
    .kind     (dec_kind),
    .word_addr(dec_word_addr),
    .bit_idx  (dec_bit_idx)
  );

  bb_bitmerge u_merge (
    .word_in (dn_rsp_rdata),
    .sel     (cur_bit_idx),
    .new_val (cur_bit_val),
    .word_out(merged_word),
    .picked  (picked_bit)
  );

  bb_ctrl #(
    .ADDR_W(ADDR_W)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .up_req_valid (up_req_valid),
    .up_req_ready (up_req_ready),
    .up_req_write (up_req_write),
    .up_req_wdata (up_req_wdata),
    .dec_kind     (dec_kind),
    .dec_word_addr(dec_word_addr),
    .dec_bit_idx  (dec_bit_idx),
    .up_rsp_valid (up_rsp_valid),
    .up_rsp_ready (up_rsp_ready),
    .up_rsp_rdata (up_rsp_rdata),
    .up_rsp_err   (up_rsp_err),
    .dn_req_valid (dn_req_valid),
    .dn_req_ready (dn_req_ready),
    .dn_req_write (dn_req_write),
    .dn_req_addr  (dn_req_addr),
    .dn_req_wdata (dn_req_wdata),
    .dn_rsp_valid (dn_rsp_valid),
    .dn_rsp_rdata (dn_rsp_rdata),
    .cur_bit_idx  (cur_bit_idx),
    .cur_bit_val  (cur_bit_val),
    .merged_word  (merged_word),
    .picked_bit   (picked_bit)
  );

endmodule

// File: rtl/bitband_bridge_chk.sv
module bitband_bridge_chk #(
  parameter int                ADDR_W       = 32,
  parameter logic [ADDR_W-1:0] ALIAS_BASE   = 'h4200_0000,
  parameter int                DIRECT_WORDS = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              up_req_valid,
  input logic              up_req_ready,
  input logic              up_req_write,
  input logic [ADDR_W-1:0] up_req_addr,
  input logic              up_rsp_valid,
  input logic              up_rsp_ready,
  input logic [31:0]       up_rsp_rdata,
  input logic              up_rsp_err,
  input logic              dn_req_valid,
  input logic              dn_req_ready,
  input logic              dn_req_write,
  input logic [ADDR_W-1:0] dn_req_addr,
  input logic [31:0]       dn_req_wdata
);

  localparam logic [ADDR_W:0] A_LO = {1'b0, ALIAS_BASE};
  localparam logic [ADDR_W:0] A_HI = A_LO + (ADDR_W+1)'(DIRECT_WORDS * 128);

  logic       busy;
  logic [2:0] dn_cnt;
  logic       alias_rd_q;
  logic       alias_wr_q;
  logic       in_alias;
  logic       unused_bit0;

  assign in_alias    = ({1'b0, up_req_addr} >= A_LO) && ({1'b0, up_req_addr} < A_HI);
  assign unused_bit0 = up_rsp_rdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      dn_cnt     <= '0;
      alias_rd_q <= 1'b0;
      alias_wr_q <= 1'b0;
    end else begin
      if (up_req_valid && up_req_ready) begin
        busy       <= 1'b1;
        dn_cnt     <= '0;
        alias_rd_q <= in_alias && !up_req_write;
        alias_wr_q <= in_alias && up_req_write;
      end else begin
        if (up_rsp_valid && up_rsp_ready) busy <= 1'b0;
        if (dn_req_valid && dn_req_ready && dn_cnt != 3'd7) dn_cnt <= dn_cnt + 3'd1;
      end
    end
  end

  // R6: no new request accepted while an access is open
  p_no_accept_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !up_req_ready);

  // R6: a response only exists for an accepted request
  p_rsp_has_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    up_rsp_valid |-> busy);

  // R9: response held under back-pressure
  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (up_rsp_valid && !up_rsp_ready) |=>
      (up_rsp_valid && $stable(up_rsp_rdata) && $stable(up_rsp_err)));

  // R10: downstream request held under stall
  p_dn_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_req_valid && !dn_req_ready) |=>
      (dn_req_valid && $stable(dn_req_addr) && $stable(dn_req_write) && $stable(dn_req_wdata)));

  // R8: error responses cause no downstream traffic
  p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (up_rsp_valid && up_rsp_err) |-> (dn_cnt == 3'd0 && up_rsp_rdata == 32'd0));

  // R4: an alias write takes exactly two downstream transfers
  p_rmw_two_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (up_rsp_valid && alias_wr_q) |-> (dn_cnt == 3'd2));

  // R5: an alias read returns only bit 0 and uses one transfer
  p_alias_rd_bit0_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (up_rsp_valid && alias_rd_q) |-> (up_rsp_rdata[31:1] == 31'd0 && dn_cnt == 3'd1));

endmodule

bind bitband_bridge bitband_bridge_chk #(
  .ADDR_W      (ADDR_W),
  .ALIAS_BASE  (ALIAS_BASE),
  .DIRECT_WORDS(DIRECT_WORDS)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .up_req_valid(up_req_valid),
  .up_req_ready(up_req_ready),
  .up_req_write(up_req_write),
  .up_req_addr (up_req_addr),
  .up_rsp_valid(up_rsp_valid),
  .up_rsp_ready(up_rsp_ready),
  .up_rsp_rdata(up_rsp_rdata),
  .up_rsp_err  (up_rsp_err),
  .dn_req_valid(dn_req_valid),
  .dn_req_ready(dn_req_ready),
  .dn_req_write(dn_req_write),
  .dn_req_addr (dn_req_addr),
  .dn_req_wdata(dn_req_wdata)
);

// File: tb/tb_bitband_bridge.sv
`timescale 1ns/1ps
module tb_bitband_bridge;

  localparam logic [31:0] DB = 32'h4000_0000;
  localparam logic [31:0] AB = 32'h4200_0000;
  localparam int          NW = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        up_req_valid = 1'b0;
  logic        up_req_ready;
  logic        up_req_write = 1'b0;
  logic [31:0] up_req_addr = '0;
  logic [31:0] up_req_wdata = '0;
  logic        up_rsp_valid;
  logic        up_rsp_ready = 1'b1;
  logic [31:0] up_rsp_rdata;
  logic        up_rsp_err;
  logic        dn_req_valid;
  logic        dn_req_ready = 1'b1;
  logic        dn_req_write;
  logic [31:0] dn_req_addr;
  logic [31:0] dn_req_wdata;
  logic        dn_rsp_valid = 1'b0;
  logic [31:0] dn_rsp_rdata = '0;

  always #5 clk = ~clk;

  bitband_bridge #(
    .ADDR_W(32), .DIRECT_BASE(DB), .DIRECT_WORDS(NW), .ALIAS_BASE(AB)
  ) dut (.*);

  int total = 0;
  int bad   = 0;
  int leak  = 0;
  bit done  = 0;

  // ---------------- downstream memory model ----------------
  logic [31:0] mem [NW];
  logic [31:0] ref_mem [NW];
  int          lat = 1;
  bit          stall_mode = 0;
  int          cyc = 0;
  int          rd_cnt = 0, wr_cnt = 0, wr_seen_rd = 0, wait_cnt = 0, stall_seen = 0;
  logic [31:0] last_rd_addr = '0, last_wr_addr = '0, rd_hold = '0;

  function automatic logic [31:0] init_word(int i);
    return 32'h1357_9BDF ^ (i * 32'h0101_0003);
  endfunction

  function automatic logic [31:0] aa(int w, int b);
    return AB + w * 128 + b * 4;
  endfunction

  initial begin
    for (int i = 0; i < NW; i++) begin
      mem[i]     = init_word(i);
      ref_mem[i] = init_word(i);
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    dn_req_ready <= !stall_mode || (cyc % 3 == 2);
    dn_rsp_valid <= 1'b0;
    if (wait_cnt != 0) begin
      wait_cnt <= wait_cnt - 1;
      if (wait_cnt == 1) begin
        dn_rsp_valid <= 1'b1;
        dn_rsp_rdata <= rd_hold;
      end
    end
    if (rst_n && dn_req_valid && !dn_req_ready) stall_seen <= stall_seen + 1;
    if (rst_n && dn_req_valid && dn_req_ready) begin
      if (dn_req_write) begin
        mem[((dn_req_addr - DB) >> 2) & 32'd63] <= dn_req_wdata;
        wr_cnt       <= wr_cnt + 1;
        wr_seen_rd   <= rd_cnt;
        last_wr_addr <= dn_req_addr;
      end else begin
        rd_hold      <= mem[((dn_req_addr - DB) >> 2) & 32'd63];
        wait_cnt     <= lat;
        rd_cnt       <= rd_cnt + 1;
        last_rd_addr <= dn_req_addr;
      end
    end
  end

  // downstream hold monitor (R10)
  int          dn_hold_bad = 0;
  logic        pv = 0, pr = 0, pw = 0;
  logic [31:0] pa = '0, pd = '0;
  always @(negedge clk) begin
    if (rst_n && pv && !pr &&
        !(dn_req_valid && dn_req_addr == pa && dn_req_write == pw && dn_req_wdata == pd))
      dn_hold_bad <= dn_hold_bad + 1;
    pv <= dn_req_valid; pr <= dn_req_ready; pw <= dn_req_write;
    pa <= dn_req_addr;  pd <= dn_req_wdata;
  end

  // ---------------- helpers ----------------
  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [31:0] addr, input logic [31:0] wd,
                        input int hold, output logic [31:0] rd, output logic err,
                        output bit stable);
    @(negedge clk);
    up_rsp_ready = (hold == 0);
    up_req_valid = 1'b1; up_req_write = wr; up_req_addr = addr; up_req_wdata = wd;
    while (!up_req_ready) @(negedge clk);
    @(negedge clk);
    up_req_valid = 1'b0;
    while (!up_rsp_valid) begin
      if (up_req_ready) leak++;
      @(negedge clk);
    end
    rd = up_rsp_rdata; err = up_rsp_err; stable = 1;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      if (!up_rsp_valid || up_rsp_rdata != rd || up_rsp_err != err) stable = 0;
      if (up_req_ready) leak++;
    end
    if (hold != 0) begin
      up_rsp_ready = 1'b1;
      @(negedge clk);
    end
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    check(up_req_ready == 1'b1, "R11 req_ready after reset", {31'd0, up_req_ready}, 32'd1);
    check(up_rsp_valid == 1'b0, "R11 rsp_valid after reset", {31'd0, up_rsp_valid}, 32'd0);
    check(dn_req_valid == 1'b0, "R11 dn_valid after reset", {31'd0, dn_req_valid}, 32'd0);
  endtask

  task automatic t_direct();
    logic [31:0] rd; logic err; bit st;
    access(1, DB + 3*4, 32'hDEAD_BEEF, 0, rd, err, st);
    ref_mem[3] = 32'hDEAD_BEEF;
    check(err == 0, "R1 direct write no err", {31'd0, err}, 32'd0);
    access(0, DB + 3*4, 0, 0, rd, err, st);
    check(rd == ref_mem[3], "R1 direct readback", rd, ref_mem[3]);
    access(0, DB + 10*4, 0, 0, rd, err, st);
    check(rd == ref_mem[10], "R1 direct read word 10", rd, ref_mem[10]);
    access(0, DB + 63*4, 0, 0, rd, err, st);
    check(rd == ref_mem[63], "R1 direct read last word", rd, ref_mem[63]);
  endtask

  task automatic alias_flip(int w, int b, string tag);
    logic [31:0] rd; logic err; bit st; logic nb;
    int r0, w0;
    nb = ~ref_mem[w][b];
    r0 = rd_cnt; w0 = wr_cnt;
    access(1, aa(w, b), {31'd0, nb}, 0, rd, err, st);
    ref_mem[w][b] = nb;
    check(rd_cnt - r0 == 1 && wr_cnt - w0 == 1, {tag, " R4 one read one write"},
          rd_cnt - r0, 32'd1);
    check(wr_seen_rd == r0 + 1, {tag, " R4 read precedes write"}, wr_seen_rd, r0 + 1);
    check(last_wr_addr == DB + w*4 && last_rd_addr == DB + w*4, {tag, " R2 word address"},
          last_wr_addr, DB + w*4);
    access(0, DB + w*4, 0, 0, rd, err, st);
    check(rd == ref_mem[w], {tag, " R2 R4 bit set, neighbours kept"}, rd, ref_mem[w]);
  endtask

  task automatic t_alias_write();
    alias_flip(5, 0, "w5b0");
    alias_flip(5, 31, "w5b31");
    alias_flip(6, 13, "w6b13");
    alias_flip(63, 7, "w63b7");
    alias_flip(6, 13, "w6b13 again");
  endtask

  task automatic t_alias_lsb();
    logic [31:0] rd; logic err; bit st;
    access(1, aa(7, 4), 32'hFFFF_FFFE, 0, rd, err, st);
    ref_mem[7][4] = 1'b0;
    access(0, DB + 7*4, 0, 0, rd, err, st);
    check(rd == ref_mem[7], "R3 upper data bits ignored (clear)", rd, ref_mem[7]);
    access(1, aa(7, 4), 32'h0000_0001, 0, rd, err, st);
    ref_mem[7][4] = 1'b1;
    access(1, aa(7, 4) + 2, 32'h8000_0002, 0, rd, err, st);
    ref_mem[7][4] = 1'b0;
    access(0, DB + 7*4, 0, 0, rd, err, st);
    check(rd == ref_mem[7], "R3 R2 low addr bits and upper data ignored", rd, ref_mem[7]);
  endtask

  task automatic t_alias_read();
    logic [31:0] rd; logic err; bit st; int r0, w0, nbad;
    r0 = rd_cnt; w0 = wr_cnt; nbad = 0;
    for (int b = 0; b < 32; b++) begin
      access(0, aa(9, b), 0, 0, rd, err, st);
      if (rd != {31'd0, ref_mem[9][b]}) nbad++;
    end
    check(nbad == 0, "R5 alias read bit in bit0", nbad, 0);
    check(rd_cnt - r0 == 32 && wr_cnt == w0, "R5 one read no write", rd_cnt - r0, 32);
  endtask

  task automatic t_latency();
    logic [31:0] rd; logic err; bit st;
    stall_mode = 1; lat = 17;
    alias_flip(12, 22, "lat17");
    lat = 3;
    access(0, aa(12, 22), 0, 0, rd, err, st);
    check(rd == {31'd0, ref_mem[12][22]}, "R7 alias read with stall", rd, {31'd0, ref_mem[12][22]});
    check(stall_seen > 0 && dn_hold_bad == 0, "R10 downstream request held", dn_hold_bad, 0);
    stall_mode = 0; lat = 1;
  endtask

  task automatic t_bad();
    logic [31:0] rd; logic err; bit st; int r0, w0;
    logic [31:0] addrs [4];
    addrs[0] = DB - 4; addrs[1] = DB + NW*4; addrs[2] = AB - 4; addrs[3] = AB + NW*128;
    for (int i = 0; i < 4; i++) begin
      r0 = rd_cnt; w0 = wr_cnt;
      access(i[0], addrs[i], 32'hFFFF_FFFF, 0, rd, err, st);
      check(err == 1 && rd == 0, "R8 error response", {31'd0, err}, 32'd1);
      check(rd_cnt == r0 && wr_cnt == w0, "R8 no downstream traffic", rd_cnt - r0, 0);
    end
    access(0, DB + 8, 0, 0, rd, err, st);
    check(err == 0 && rd == ref_mem[2], "R8 in-range after error", rd, ref_mem[2]);
  endtask

  task automatic t_rsp_hold();
    logic [31:0] rd; logic err; bit st;
    access(0, DB + 11*4, 0, 4, rd, err, st);
    check(st && rd == ref_mem[11], "R9 response held under back-pressure", rd, ref_mem[11]);
  endtask

  task automatic t_consist();
    logic [31:0] rd; logic err; bit st;
    access(1, DB + 20*4, 32'h0000_00F0, 0, rd, err, st);
    ref_mem[20] = 32'h0000_00F0;
    access(0, aa(20, 4), 0, 0, rd, err, st);
    check(rd == 32'd1, "R12 alias sees direct write (bit4)", rd, 32'd1);
    access(0, aa(20, 3), 0, 0, rd, err, st);
    check(rd == 32'd0, "R12 alias sees direct write (bit3)", rd, 32'd0);
    access(1, aa(20, 3), 32'd1, 0, rd, err, st);
    access(0, DB + 20*4, 0, 0, rd, err, st);
    check(rd == 32'h0000_00F8, "R12 direct sees alias write", rd, 32'h0000_00F8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_direct();
    t_alias_write();
    t_alias_lsb();
    t_alias_read();
    t_latency();
    t_bad();
    t_rsp_hold();
    t_consist();
    check(leak == 0, "R6 req_ready low during access", leak, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=0", 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule